// File: doc/BRIEF.md
# Display Controller Host Configuration Port

This block is the host-side front end of a display controller. A processor drives an asynchronous 16-bit parallel bus with chip-select, write-strobe and read-strobe lines, plus one select line. When the select line is low, the written word is a command. When it is high, the word is a parameter. The block brings the strobes into its own clock domain. It keeps the most recent command code and counts the parameter words that arrive after it. Each parameter is steered into one slice of a configuration record.

The configuration record holds several groups of settings: the PLL multiplier and divider with their enable and clock-select controls, a 20-bit pixel-clock ratio, panel mode and size, horizontal and vertical timing, the pixel data format, and the display-enable flag. All of these fields leave the block as plain outputs for the timing generator and the clock logic. The block also answers an identification query with a fixed sequence of read words. It gives one-clock strobes for the start of a pixel-memory write and, through a soft-reset command, for restoring the whole record.

Top module: `lcdc_host_cfg`

## Requirements
- R1: A completed write with `bus_sel` low is a command. Only bits [7:0] form the code, and bits [15:8] are ignored. Every command restarts parameter counting at the first parameter, even when it repeats the previous code.
- R2: Code 0xE2 takes three parameters. The first, bits [7:0], is the multiplier. The second, bits [3:0], is the divider. `pll_mult`/`pll_div` change only when bit 2 of the third parameter is 1, and then they take the staged values. When that bit is 0 the outputs keep their values.
- R3: Code 0xE0 takes one parameter. Bit 0 drives `pll_enable`. `pll_select` becomes 1 only when bits 1 and 0 are both set and `pll_enable` was already 1 before this write. Otherwise `pll_select` becomes 0.
- R4: Code 0xE6 takes three parameters that form `pclk_ratio`: bits [19:16] from parameter 1 bits [3:0], bits [15:8] from parameter 2, and bits [7:0] from parameter 3.
- R5: Code 0xB0 takes seven parameters, in order: mode (bits [5:0]), panel type (bits [6:5]), horizontal size high (bits [2:0]) then low byte, vertical size high then low byte, and RGB order (bits [5:0]).
- R6: Code 0xB4 takes eight parameters, in order: total high/low, sync position high/low, sync width (bits [6:0]), line start high/low, and sub-pixel offset (bits [1:0]). Each high parameter supplies bits [10:8] from its bits [2:0].
- R7: Code 0xB6 takes seven parameters, in order: vertical total high/low, sync position high/low, sync width (bits [6:0]), and frame start high/low.
- R8: Code 0xF0 takes one parameter whose bits [2:0] set `pix_format`. The reserved code 3'b111 leaves `pix_format` unchanged.
- R9: After command 0xA1, successive reads return 0x0001, 0x0057, 0x0061, 0x0001, 0x00FF, and 0x0000 from then on. Reads after any other command return 0x0000. `bus_doe` is high exactly while `bus_cs_n` and `bus_rd_n` are both low.
- R10: Command 0x29 sets `display_on`. Command 0x2C raises `mem_write_start` for exactly one clock.
- R11: Parameters beyond the count defined for the current code change nothing. Parameters after an unknown code (for example 0x55) change no output.
- R12: Command 0x01 restores every configuration output to its reset value one clock after the command is taken.
- R13: Reset values: mult 0x2D, div 0x3, PLL enable/select 0, pclk_ratio 0x7FFFF, mode 0, type 2'b01, h size 0x27F, v size 0x1DF, RGB order 0, h total 0x2AF, h sync pos 0x020, h sync width 0x07, line start 0, sub 0, v total 0x13F, v sync pos 0x008, v sync width 0x01, frame start 0, pix_format 3'b101, display_on 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Host chip select, active low |
| bus_wr_n | input | 1 | Host write strobe, active low; the word is taken when it rises |
| bus_rd_n | input | 1 | Host read strobe, active low |
| bus_sel | input | 1 | 0 = command word, 1 = parameter word |
| bus_din | input | 16 | Host write data |
| bus_dout | output | 16 | Read data |
| bus_doe | output | 1 | Read data output enable |
| pll_mult | output | 8 | PLL multiplier |
| pll_div | output | 4 | PLL divider |
| pll_enable | output | 1 | PLL enable |
| pll_select | output | 1 | Use PLL output as system clock |
| pclk_ratio | output | 20 | Pixel-clock ratio |
| panel_mode | output | 6 | Panel mode bits |
| panel_type | output | 2 | Panel type |
| h_active | output | 11 | Horizontal size minus one |
| v_active | output | 11 | Vertical size minus one |
| rgb_order | output | 6 | Line RGB order codes |
| h_total | output | 11 | Horizontal total |
| h_sync_pos | output | 11 | Horizontal sync position |
| h_sync_width | output | 7 | Horizontal sync width |
| h_line_start | output | 11 | Horizontal line start |
| h_sub_offset | output | 2 | Sub-pixel offset |
| v_total | output | 11 | Vertical total |
| v_sync_pos | output | 11 | Vertical sync position |
| v_sync_width | output | 7 | Vertical sync width |
| v_frame_start | output | 11 | Vertical frame start |
| pix_format | output | 3 | Pixel data format code |
| display_on | output | 1 | Display enable |
| mem_write_start | output | 1 | One-clock pulse on a memory-write command |

## Verification
Two cases are hard to reach from the ports because each depends on history in the command stream rather than on a single word. The first is the PLL clock-select rule, which looks at the enable state from an earlier write. The stimulus writes 0x03 from the disabled state and again after enabling, and then 0x02 while enabled. The second is parameter overflow and restart: the bench sends more parameters than a code defines, and it cuts a sequence short with a repeated command before sending new values. Randomised timing sequences with a fixed seed are mixed with these directed streams, and every output is compared with a bench-side model after each sequence.

// File: rtl/lhc_pkg.sv
package lhc_pkg;
  localparam int DATA_W  = 16;
  localparam int CODE_W  = 8;
  localparam int PCNT_W  = 4;
  localparam int DIM_W   = 11;
  localparam int RATIO_W = 20;
  localparam int RIDX_W  = 3;
  localparam int ID_LEN  = 5;

  typedef struct packed {
    logic [7:0]         mult;
    logic [3:0]         div;
    logic               pll_en;
    logic               pll_use;
    logic [RATIO_W-1:0] ratio;
    logic [5:0]         mode;
    logic [1:0]         ptype;
    logic [DIM_W-1:0]   hsize;
    logic [DIM_W-1:0]   vsize;
    logic [5:0]         rgb;
    logic [DIM_W-1:0]   ht;
    logic [DIM_W-1:0]   hps;
    logic [6:0]         hpw;
    logic [DIM_W-1:0]   lps;
    logic [1:0]         hsub;
    logic [DIM_W-1:0]   vt;
    logic [DIM_W-1:0]   vps;
    logic [6:0]         vpw;
    logic [DIM_W-1:0]   fps;
    logic [2:0]         pfmt;
    logic               disp_on;
  } cfg_t;

  localparam cfg_t CFG_POR = '{
    mult: 8'h2D, div: 4'h3, pll_en: 1'b0, pll_use: 1'b0,
    ratio: 20'h7FFFF, mode: 6'h00, ptype: 2'b01,
    hsize: 11'h27F, vsize: 11'h1DF, rgb: 6'h00,
    ht: 11'h2AF, hps: 11'h020, hpw: 7'h07, lps: 11'h000, hsub: 2'b00,
    vt: 11'h13F, vps: 11'h008, vpw: 7'h01, fps: 11'h000,
    pfmt: 3'b101, disp_on: 1'b0
  };

  localparam logic [CODE_W-1:0] OP_NOP      = 8'h00;
  localparam logic [CODE_W-1:0] OP_SRST     = 8'h01;
  localparam logic [CODE_W-1:0] OP_DISP_ON  = 8'h29;
  localparam logic [CODE_W-1:0] OP_MEM_WR   = 8'h2C;
  localparam logic [CODE_W-1:0] OP_ID       = 8'hA1;
  localparam logic [CODE_W-1:0] OP_PANEL    = 8'hB0;
  localparam logic [CODE_W-1:0] OP_HTIME    = 8'hB4;
  localparam logic [CODE_W-1:0] OP_VTIME    = 8'hB6;
  localparam logic [CODE_W-1:0] OP_PLL_CTL  = 8'hE0;
  localparam logic [CODE_W-1:0] OP_PLL_MN   = 8'hE2;
  localparam logic [CODE_W-1:0] OP_PCLK     = 8'hE6;
  localparam logic [CODE_W-1:0] OP_PIXFMT   = 8'hF0;

  function automatic logic [PCNT_W-1:0] prm_count(input logic [CODE_W-1:0] op);
    case (op)
      OP_PLL_MN:  prm_count = 4'd3;
      OP_PLL_CTL: prm_count = 4'd1;
      OP_PCLK:    prm_count = 4'd3;
      OP_PANEL:   prm_count = 4'd7;
      OP_HTIME:   prm_count = 4'd8;
      OP_VTIME:   prm_count = 4'd7;
      OP_PIXFMT:  prm_count = 4'd1;
      default:    prm_count = 4'd0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] id_word(input logic [RIDX_W-1:0] idx);
    case (idx)
      3'd0:    id_word = 16'h0001;
      3'd1:    id_word = 16'h0057;
      3'd2:    id_word = 16'h0061;
      3'd3:    id_word = 16'h0001;
      3'd4:    id_word = 16'h00FF;
      default: id_word = 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/lhc_bus_sync.sv
module lhc_bus_sync #(
  parameter int SYNC_STAGES = 2,
  parameter int DW          = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          sel,
  input  logic [DW-1:0] din,
  output logic          wr_done,
  output logic          rd_done,
  output logic          hold_sel,
  output logic [DW-1:0] hold_word
);
  localparam int NCH = 2;

  logic [NCH-1:0] raw;
  logic [NCH-1:0] act;
  logic [NCH-1:0] done;

  assign raw[0] = ~cs_n & ~wr_n;
  assign raw[1] = ~cs_n & ~rd_n;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [SYNC_STAGES-1:0] sh_q, sh_n;
    logic                   last_q, last_n;

    always_comb begin
      sh_n   = {sh_q[SYNC_STAGES-2:0], raw[ch]};
      last_n = sh_q[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q   <= '0;
        last_q <= 1'b0;
      end else begin
        sh_q   <= sh_n;
        last_q <= last_n;
      end
    end

    assign act[ch]  = sh_q[SYNC_STAGES-1];
    assign done[ch] = last_q & ~sh_q[SYNC_STAGES-1];
  end

  logic          hsel_q, hsel_n;
  logic [DW-1:0] hword_q, hword_n;

  always_comb begin
    hsel_n  = hsel_q;
    hword_n = hword_q;
    if (act[0]) begin
      hsel_n  = sel;
      hword_n = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsel_q  <= 1'b0;
      hword_q <= '0;
    end else begin
      hsel_q  <= hsel_n;
      hword_q <= hword_n;
    end
  end

  assign wr_done   = done[0];
  assign rd_done   = done[1];
  assign hold_sel  = hsel_q;
  assign hold_word = hword_q;
endmodule

// File: rtl/lhc_cmd_seq.sv
module lhc_cmd_seq
  import lhc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_done,
  input  logic              rd_done,
  input  logic              wsel,
  input  logic [DATA_W-1:0] wword,
  output logic [CODE_W-1:0] op,
  output logic [PCNT_W-1:0] prm_idx,
  output logic              prm_we,
  output logic              cmd_we,
  output logic [CODE_W-1:0] cmd_code,
  output logic [RIDX_W-1:0] rd_idx,
  output logic              mem_wr_start
);
  localparam logic [RIDX_W-1:0] RD_LAST = RIDX_W'(ID_LEN);

  logic [CODE_W-1:0] op_q, op_n;
  logic [PCNT_W-1:0] cnt_q, cnt_n;
  logic [RIDX_W-1:0] rd_q, rd_n;
  logic              mws_q, mws_n;
  logic              cmd_evt, prm_evt, prm_ok;

  always_comb begin
    cmd_evt = wr_done & ~wsel;
    prm_evt = wr_done & wsel;
    prm_ok  = prm_evt && (cnt_q < prm_count(op_q));
    op_n    = op_q;
    cnt_n   = cnt_q;
    rd_n    = rd_q;
    mws_n   = 1'b0;
    if (cmd_evt) begin
      op_n  = wword[CODE_W-1:0];
      cnt_n = '0;
      rd_n  = '0;
      mws_n = (wword[CODE_W-1:0] == OP_MEM_WR);
    end else begin
      if (prm_ok) cnt_n = cnt_q + 1'b1;
      if (rd_done && (op_q == OP_ID) && (rd_q != RD_LAST)) rd_n = rd_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_NOP;
      cnt_q <= '0;
      rd_q  <= '0;
      mws_q <= 1'b0;
    end else begin
      op_q  <= op_n;
      cnt_q <= cnt_n;
      rd_q  <= rd_n;
      mws_q <= mws_n;
    end
  end

  assign op           = op_q;
  assign prm_idx      = cnt_q;
  assign prm_we       = prm_ok;
  assign cmd_we       = cmd_evt;
  assign cmd_code     = wword[CODE_W-1:0];
  assign rd_idx       = rd_q;
  assign mem_wr_start = mws_q;
endmodule

// File: rtl/lhc_cfg_regs.sv
module lhc_cfg_regs
  import lhc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              prm_we,
  input  logic [CODE_W-1:0] op,
  input  logic [PCNT_W-1:0] prm_idx,
  input  logic [7:0]        pd,
  output cfg_t              cfg
);
  cfg_t       cfg_q, cfg_n;
  logic [7:0] mult_stg_q, mult_stg_n;
  logic [3:0] div_stg_q, div_stg_n;

  always_comb begin
    cfg_n      = cfg_q;
    mult_stg_n = mult_stg_q;
    div_stg_n  = div_stg_q;
    if (cmd_we) begin
      case (cmd_code)
        OP_SRST: begin
          cfg_n      = CFG_POR;
          mult_stg_n = CFG_POR.mult;
          div_stg_n  = CFG_POR.div;
        end
        OP_DISP_ON: cfg_n.disp_on = 1'b1;
        default: ;
      endcase
    end else if (prm_we) begin
      case (op)
        OP_PLL_MN: begin
          case (prm_idx)
            4'd0: mult_stg_n = pd;
            4'd1: div_stg_n  = pd[3:0];
            4'd2: if (pd[2]) begin
              cfg_n.mult = mult_stg_q;
              cfg_n.div  = div_stg_q;
            end
            default: ;
          endcase
        end
        OP_PLL_CTL: begin
          cfg_n.pll_en  = pd[0];
          cfg_n.pll_use = pd[1] & pd[0] & cfg_q.pll_en;
        end
        OP_PCLK: begin
          case (prm_idx)
            4'd0: cfg_n.ratio[19:16] = pd[3:0];
            4'd1: cfg_n.ratio[15:8]  = pd;
            4'd2: cfg_n.ratio[7:0]   = pd;
            default: ;
          endcase
        end
        OP_PANEL: begin
          case (prm_idx)
            4'd0: cfg_n.mode         = pd[5:0];
            4'd1: cfg_n.ptype        = pd[6:5];
            4'd2: cfg_n.hsize[10:8]  = pd[2:0];
            4'd3: cfg_n.hsize[7:0]   = pd;
            4'd4: cfg_n.vsize[10:8]  = pd[2:0];
            4'd5: cfg_n.vsize[7:0]   = pd;
            4'd6: cfg_n.rgb          = pd[5:0];
            default: ;
          endcase
        end
        OP_HTIME: begin
          case (prm_idx)
            4'd0: cfg_n.ht[10:8]  = pd[2:0];
            4'd1: cfg_n.ht[7:0]   = pd;
            4'd2: cfg_n.hps[10:8] = pd[2:0];
            4'd3: cfg_n.hps[7:0]  = pd;
            4'd4: cfg_n.hpw       = pd[6:0];
            4'd5: cfg_n.lps[10:8] = pd[2:0];
            4'd6: cfg_n.lps[7:0]  = pd;
            4'd7: cfg_n.hsub      = pd[1:0];
            default: ;
          endcase
        end
        OP_VTIME: begin
          case (prm_idx)
            4'd0: cfg_n.vt[10:8]  = pd[2:0];
            4'd1: cfg_n.vt[7:0]   = pd;
            4'd2: cfg_n.vps[10:8] = pd[2:0];
            4'd3: cfg_n.vps[7:0]  = pd;
            4'd4: cfg_n.vpw       = pd[6:0];
            4'd5: cfg_n.fps[10:8] = pd[2:0];
            4'd6: cfg_n.fps[7:0]  = pd;
            default: ;
          endcase
        end
        OP_PIXFMT: if (pd[2:0] != 3'b111) cfg_n.pfmt = pd[2:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= CFG_POR;
      mult_stg_q <= CFG_POR.mult;
      div_stg_q  <= CFG_POR.div;
    end else begin
      cfg_q      <= cfg_n;
      mult_stg_q <= mult_stg_n;
      div_stg_q  <= div_stg_n;
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/lcdc_host_cfg.sv
module lcdc_host_cfg
  import lhc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_cs_n,
  input  logic        bus_wr_n,
  input  logic        bus_rd_n,
  input  logic        bus_sel,
  input  logic [15:0] bus_din,
  output logic [15:0] bus_dout,
  output logic        bus_doe,
  output logic [7:0]  pll_mult,
  output logic [3:0]  pll_div,
  output logic        pll_enable,
  output logic        pll_select,
  output logic [19:0] pclk_ratio,
  output logic [5:0]  panel_mode,
  output logic [1:0]  panel_type,
  output logic [10:0] h_active,
  output logic [10:0] v_active,
  output logic [5:0]  rgb_order,
  output logic [10:0] h_total,
  output logic [10:0] h_sync_pos,
  output logic [6:0]  h_sync_width,
  output logic [10:0] h_line_start,
  output logic [1:0]  h_sub_offset,
  output logic [10:0] v_total,
  output logic [10:0] v_sync_pos,
  output logic [6:0]  v_sync_width,
  output logic [10:0] v_frame_start,
  output logic [2:0]  pix_format,
  output logic        display_on,
  output logic        mem_write_start
);
  logic [1:0] rst_q, rst_n2;
  logic       rst_n_i;

  always_comb rst_n2 = {rst_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= rst_n2;
  end
  assign rst_n_i = rst_q[1];

  logic              wr_done, rd_done, wsel;
  logic [DATA_W-1:0] wword;
  logic [CODE_W-1:0] op, cmd_code;
  logic [PCNT_W-1:0] prm_idx;
  logic              prm_we, cmd_we;
  logic [RIDX_W-1:0] rd_idx;
  cfg_t              cfg;

  lhc_bus_sync #(.SYNC_STAGES(SYNC_STAGES), .DW(DATA_W)) u_sync (
    .clk(clk), .rst_n(rst_n_i), .cs_n(bus_cs_n), .wr_n(bus_wr_n), .rd_n(bus_rd_n),
    .sel(bus_sel), .din(bus_din), .wr_done(wr_done), .rd_done(rd_done),
    .hold_sel(wsel), .hold_word(wword)
  );

  lhc_cmd_seq u_seq (
    .clk(clk), .rst_n(rst_n_i), .wr_done(wr_done), .rd_done(rd_done),
    .wsel(wsel), .wword(wword), .op(op), .prm_idx(prm_idx), .prm_we(prm_we),
    .cmd_we(cmd_we), .cmd_code(cmd_code), .rd_idx(rd_idx), .mem_wr_start(mem_write_start)
  );

  lhc_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n_i), .cmd_we(cmd_we), .cmd_code(cmd_code),
    .prm_we(prm_we), .op(op), .prm_idx(prm_idx), .pd(wword[7:0]), .cfg(cfg)
  );

  always_comb begin
    bus_doe  = ~bus_cs_n & ~bus_rd_n;
    bus_dout = (bus_doe && op == OP_ID) ? id_word(rd_idx) : '0;
  end

  assign pll_mult      = cfg.mult;
  assign pll_div       = cfg.div;
  assign pll_enable    = cfg.pll_en;
  assign pll_select    = cfg.pll_use;
  assign pclk_ratio    = cfg.ratio;
  assign panel_mode    = cfg.mode;
  assign panel_type    = cfg.ptype;
  assign h_active      = cfg.hsize;
  assign v_active      = cfg.vsize;
  assign rgb_order     = cfg.rgb;
  assign h_total       = cfg.ht;
  assign h_sync_pos    = cfg.hps;
  assign h_sync_width  = cfg.hpw;
  assign h_line_start  = cfg.lps;
  assign h_sub_offset  = cfg.hsub;
  assign v_total       = cfg.vt;
  assign v_sync_pos    = cfg.vps;
  assign v_sync_width  = cfg.vpw;
  assign v_frame_start = cfg.fps;
  assign pix_format    = cfg.pfmt;
  assign display_on    = cfg.disp_on;
endmodule

// File: rtl/lhc_host_cfg_chk.sv
module lhc_host_cfg_chk
  import lhc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_done,
  input logic              wsel,
  input logic              cmd_we,
  input logic [CODE_W-1:0] cmd_code,
  input logic [CODE_W-1:0] op,
  input logic [PCNT_W-1:0] prm_idx,
  input cfg_t              cfg,
  input logic              mem_write_start
);
  AST_FMT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.pfmt != 3'b111); // R8

  AST_PLL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg.pll_use) |-> $past(cfg.pll_en)); // R3

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_code == OP_SRST) |=> (cfg == CFG_POR)); // R12

  AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && wsel && prm_count(op) == 4'd0) |=> $stable(cfg)); // R11

  AST_CMD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> (prm_idx == '0)); // R1

  AST_MWR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_write_start |=> !mem_write_start); // R10
endmodule

bind lcdc_host_cfg lhc_host_cfg_chk u_chk (
  .clk(clk), .rst_n(rst_n_i), .wr_done(wr_done), .wsel(wsel),
  .cmd_we(cmd_we), .cmd_code(cmd_code), .op(op), .prm_idx(prm_idx),
  .cfg(cfg), .mem_write_start(mem_write_start)
);

// File: tb/lcdc_host_cfg_bench.sv
module lcdc_host_cfg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_cs_n = 1'b1, bus_wr_n = 1'b1, bus_rd_n = 1'b1, bus_sel = 1'b0;
  logic [15:0] bus_din = '0;
  logic [15:0] bus_dout;
  logic        bus_doe;
  logic [7:0]  pll_mult;
  logic [3:0]  pll_div;
  logic        pll_enable, pll_select;
  logic [19:0] pclk_ratio;
  logic [5:0]  panel_mode, rgb_order;
  logic [1:0]  panel_type, h_sub_offset;
  logic [10:0] h_active, v_active, h_total, h_sync_pos, h_line_start;
  logic [10:0] v_total, v_sync_pos, v_frame_start;
  logic [6:0]  h_sync_width, v_sync_width;
  logic [2:0]  pix_format;
  logic        display_on, mem_write_start;

  int checks = 0;
  int errors = 0;
  int mws_cnt = 0;

  always #10 clk = ~clk;

  lcdc_host_cfg u_lcdc_host_cfg (.*);

  always @(posedge clk) if (mem_write_start) mws_cnt <= mws_cnt + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic sel, input logic [15:0] w);
    @(negedge clk);
    bus_sel = sel; bus_din = w; bus_cs_n = 1'b0; bus_wr_n = 1'b0;
    repeat (4) @(negedge clk);
    bus_wr_n = 1'b1; bus_cs_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic wcmd(input logic [7:0] c);
    bus_write(1'b0, {8'($urandom), c});
  endtask

  task automatic wprm(input logic [7:0] p);
    bus_write(1'b1, {8'($urandom), p});
  endtask

  task automatic bus_read(output logic [15:0] d, output logic oe);
    @(negedge clk);
    bus_cs_n = 1'b0; bus_rd_n = 1'b0;
    repeat (3) @(negedge clk);
    d = bus_dout; oe = bus_doe;
    bus_rd_n = 1'b1; bus_cs_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  function automatic logic [7:0] hi3(input logic [10:0] v);
    return {5'b0, v[10:8]};
  endfunction

  function automatic logic [15:0] id_exp(input int i);
    case (i)
      0: return 16'h0001;
      1: return 16'h0057;
      2: return 16'h0061;
      3: return 16'h0001;
      4: return 16'h00FF;
      default: return 16'h0000;
    endcase
  endfunction

  logic [10:0] e_ht, e_hps, e_lps, e_vt, e_vps, e_fps;
  logic [6:0]  e_hpw, e_vpw;
  logic [1:0]  e_hsub;
  logic [19:0] e_ratio;

  task automatic set_por;
    e_ht = 11'h2AF; e_hps = 11'h020; e_hpw = 7'h07; e_lps = 11'h000; e_hsub = 2'b00;
    e_vt = 11'h13F; e_vps = 11'h008; e_vpw = 7'h01; e_fps = 11'h000; e_ratio = 20'h7FFFF;
  endtask

  task automatic cmp_timing(input string req);
    chk(req, 32'(h_total), 32'(e_ht));
    chk(req, 32'(h_sync_pos), 32'(e_hps));
    chk(req, 32'(h_sync_width), 32'(e_hpw));
    chk(req, 32'(h_line_start), 32'(e_lps));
    chk(req, 32'(h_sub_offset), 32'(e_hsub));
    chk(req, 32'(v_total), 32'(e_vt));
    chk(req, 32'(v_sync_pos), 32'(e_vps));
    chk(req, 32'(v_sync_width), 32'(e_vpw));
    chk(req, 32'(v_frame_start), 32'(e_fps));
    chk(req, 32'(pclk_ratio), 32'(e_ratio));
  endtask

  task automatic cmp_por(input string req);
    set_por();
    cmp_timing(req);
    chk(req, 32'(pll_mult), 32'h2D);
    chk(req, 32'(pll_div), 32'h3);
    chk(req, 32'({pll_enable, pll_select}), 32'h0);
    chk(req, 32'(panel_mode), 32'h0);
    chk(req, 32'(panel_type), 32'h1);
    chk(req, 32'(h_active), 32'h27F);
    chk(req, 32'(v_active), 32'h1DF);
    chk(req, 32'(rgb_order), 32'h0);
    chk(req, 32'(pix_format), 32'h5);
    chk(req, 32'(display_on), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic        oe;
    logic [7:0]  p;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R13 reset state
    cmp_por("R13");
    chk("R9 idle doe", 32'(bus_doe), 32'h0);

    // R6 / R7 / R4 randomised timing and clock-ratio sequences
    for (int n = 0; n < 6; n++) begin
      e_ht = 11'($urandom); e_hps = 11'($urandom); e_hpw = 7'($urandom);
      e_lps = 11'($urandom); e_hsub = 2'($urandom);
      wcmd(8'hB4);
      wprm(hi3(e_ht) | 8'hF8); wprm(e_ht[7:0]);
      wprm(hi3(e_hps)); wprm(e_hps[7:0]);
      wprm({1'b1, e_hpw});
      wprm(hi3(e_lps)); wprm(e_lps[7:0]);
      wprm({6'h3F, e_hsub});
      e_vt = 11'($urandom); e_vps = 11'($urandom); e_vpw = 7'($urandom); e_fps = 11'($urandom);
      wcmd(8'hB6);
      wprm(hi3(e_vt)); wprm(e_vt[7:0]);
      wprm(hi3(e_vps)); wprm(e_vps[7:0]);
      wprm({1'b0, e_vpw});
      wprm(hi3(e_fps)); wprm(e_fps[7:0]);
      e_ratio = 20'($urandom);
      wcmd(8'hE6);
      wprm({4'hA, e_ratio[19:16]}); wprm(e_ratio[15:8]); wprm(e_ratio[7:0]);
      cmp_timing("R6 R7 R4 random");
    end

    // R1 restart: two params, repeated command, fresh sequence from HT
    wcmd(8'hB4); wprm(8'h01); wprm(8'h23);
    wcmd(8'hB4); wprm(8'h04); wprm(8'h56);
    chk("R1 restart", 32'(h_total), 32'h456);

    // R5 panel mode plus R11 excess parameters
    wcmd(8'hB0);
    wprm(8'hEA); wprm(8'h40); wprm(8'h03); wprm(8'h1F);
    wprm(8'h01); wprm(8'h0F); wprm(8'h2D); wprm(8'h3F); wprm(8'h11);
    chk("R5 mode", 32'(panel_mode), 32'h2A);
    chk("R5 type", 32'(panel_type), 32'h2);
    chk("R5 hsize", 32'(h_active), 32'h31F);
    chk("R5 vsize", 32'(v_active), 32'h10F);
    chk("R11 excess keeps rgb", 32'(rgb_order), 32'h2D);

    // R11 unknown opcode
    set_por();
    begin
      logic [10:0] ht_b;
      logic [5:0]  rgb_b;
      ht_b = h_total; rgb_b = rgb_order;
      wcmd(8'h55); wprm(8'h00); wprm(8'hFF); wprm(8'h12);
      chk("R11 unknown ht", 32'(h_total), 32'(ht_b));
      chk("R11 unknown rgb", 32'(rgb_order), 32'(rgb_b));
    end

    // R2 PLL multiplier/divider staging
    wcmd(8'hE2); wprm(8'h1D); wprm(8'h02); wprm(8'hFB);
    chk("R2 apply=0 mult", 32'(pll_mult), 32'h2D);
    chk("R2 apply=0 div", 32'(pll_div), 32'h3);
    wcmd(8'hE2); wprm(8'h1D); wprm(8'hF2); wprm(8'h04);
    chk("R2 apply=1 mult", 32'(pll_mult), 32'h1D);
    chk("R2 apply=1 div", 32'(pll_div), 32'h2);

    // R3 PLL enable ordering
    wcmd(8'hE0); wprm(8'h03);
    chk("R3 early select", 32'({pll_enable, pll_select}), 32'h2);
    wcmd(8'hE0); wprm(8'h03);
    chk("R3 ordered select", 32'({pll_enable, pll_select}), 32'h3);
    wcmd(8'hE0); wprm(8'h02);
    chk("R3 disable", 32'({pll_enable, pll_select}), 32'h0);

    // R8 pixel format, including reserved code
    wcmd(8'hF0); wprm(8'h03);
    chk("R8 565", 32'(pix_format), 32'h3);
    wcmd(8'hF0); wprm(8'hFF);
    chk("R8 reserved ignored", 32'(pix_format), 32'h3);
    for (int n = 0; n < 6; n++) begin
      p = 8'($urandom) & 8'h06;
      wcmd(8'hF0); wprm(p);
      chk("R8 random", 32'(pix_format), 32'(p[2:0]));
    end

    // R9 identification read-back
    wcmd(8'hA1);
    for (int i = 0; i < 7; i++) begin
      bus_read(d, oe);
      chk("R9 id word", 32'(d), 32'(id_exp(i)));
      chk("R9 doe", 32'(oe), 32'h1);
    end
    chk("R9 doe released", 32'(bus_doe), 32'h0);
    wcmd(8'h00);
    bus_read(d, oe);
    chk("R9 other opcode", 32'(d), 32'h0);

    // R10 display on and memory-write strobe
    wcmd(8'h29);
    chk("R10 display on", 32'(display_on), 32'h1);
    mws_cnt = 0;
    wcmd(8'h2C);
    chk("R10 write start pulse", 32'(mws_cnt), 32'h1);

    // R12 soft reset
    wcmd(8'h01);
    cmp_por("R12");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule